// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the two-wire bus protocol engine of a small serial nonvolatile memory. During a write transfer it gathers up to four data bytes of one page. The word address received after the device address fixes the page, which is the upper six address bits, and the starting slot, which is the two low bits. Each accepted byte lands in the current slot and the slot index then steps forward. The slot index wraps inside the page, so a fifth or later byte replaces one that is already held.

When the engine reports a stop at the end of a write transfer that carried at least one data byte, the block starts a self-timed write cycle. The cycle lasts a fixed number of system clock ticks, set by a parameter. A real device scales this to several milliseconds; simulation uses a short count. For the whole cycle `busy_o` is high. The protocol engine uses this flag to withhold its address acknowledge, and the block itself ignores every bus event while it is set. The slots filled in the transfer are written to the memory array one per clock, lowest slot first. These writes fall in the final cycles of the window, so the flag drops right after the last one.

Top module: `pgw_commit_top`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low and no slot is marked as filled.
- R2: A word address load sets the page to `addr_i[7:2]` and the slot index to `addr_i[1:0]`. Each data byte that is not paired with an address load is stored in the current slot, and the slot index then increments modulo 4. The page bits never change within a transfer.
- R3: When more than four bytes arrive before the stop, the slot index wraps, and a later byte overwrites the byte held in the same slot.
- R4: A stop while idle, with at least one slot filled, raises `busy_o` in the next cycle. It then stays high for exactly `CYCLE_TICKS` cycles.
- R5: A stop with no data byte accepted since the last start condition starts no cycle and issues no array write.
- R6: The commit writes only the slots filled in this transfer. There is one write per clock, in ascending slot order, to address `{page, slot}`, with the last byte stored in that slot.
- R7: With N slots filled, the writes occupy the last N cycles of the busy window, so `busy_o` falls in the cycle after the final write.
- R8: While `busy_o` is high, start, address load, data byte and stop inputs have no effect on the buffer, the mask, the page or the timer.
- R9: A start condition accepted while idle clears the filled-slot mask, so bytes from an abandoned transfer are never committed.
- R10: `arr_we_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: start condition seen on the bus |
| addr_load_i | input | 1 | One-cycle pulse: word address byte accepted |
| addr_i | input | ADDR_W | Word address for `addr_load_i` |
| byte_vld_i | input | 1 | One-cycle pulse: data byte accepted |
| byte_i | input | DATA_W | Data byte for `byte_vld_i` |
| stop_i | input | 1 | One-cycle pulse: stop condition after a write |
| busy_o | output | 1 | Self-timed write cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
The assertions assume that the protocol engine raises at most one of start, address load, data byte and stop in any cycle. They also assume that every event input is a single-cycle pulse. The stimulus drives exactly one such event, or none, per clock, always on the falling edge. It still deliberately sends full transfers while `busy_o` is high, so that the lockout is exercised. A behavioural model in the bench tracks the slots, the mask and the timer with plain integers and queues, and it is compared with the outputs on every clock.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HOLD  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      lock_i,
  input  logic                      start_i,
  input  logic                      addr_load_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      byte_vld_i,
  input  logic [DATA_W-1:0]         byte_i,
  input  logic                      take_i,
  input  logic [$clog2(SLOTS)-1:0]  rd_slot_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [ADDR_W-$clog2(SLOTS)-1:0] page_o,
  output logic [SLOTS-1:0]          valid_o
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic              accept;
  logic              byte_wr;
  logic [PAGE_W-1:0] page_q;
  logic [SLOT_W-1:0] ptr_q;
  logic [SLOTS-1:0]  valid_q;
  logic [DATA_W-1:0] data_q [SLOTS];

  assign accept  = ~lock_i;
  assign byte_wr = accept & byte_vld_i & ~addr_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ptr_q  <= '0;
    end else if (accept && addr_load_i) begin
      page_q <= addr_i[ADDR_W-1:SLOT_W];
      ptr_q  <= addr_i[SLOT_W-1:0];
    end else if (byte_wr) begin
      ptr_q  <= ptr_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 valid_q <= '0;
    else if (take_i)             valid_q <= '0;
    else if (accept && start_i)  valid_q <= '0;
    else if (byte_wr)            valid_q[ptr_q] <= 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   data_q[g] <= '0;
      else if (byte_wr && ptr_q == SLOT_W'(g))       data_q[g] <= byte_i;
    end
  end

  assign rd_data_o = data_q[rd_slot_i];
  assign page_o    = page_q;
  assign valid_o   = valid_q;

  // R2: slot index steps by one per stored byte, wrapping in the page
  a_r2_slot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_wr |=> ptr_q == $past(ptr_q) + SLOT_W'(1));
  // R8: nothing moves while locked
  a_r8_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(valid_q) && $stable(page_q) && $stable(ptr_q)));
  // R9: start empties the mask
  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && start_i) |=> valid_q == '0);
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
  parameter int CYCLE_TICKS = 40,
  parameter int CNT_W       = $clog2(CYCLE_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               remain_q <= '0;
    else if (launch_i)         remain_q <= CNT_W'(CYCLE_TICKS);
    else if (remain_q != '0)   remain_q <= remain_q - CNT_W'(1);
  end

  assign remain_o = remain_q;
  assign busy_o   = remain_q != '0;

  // R4: a launch loads the full window
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> remain_o == CNT_W'(CYCLE_TICKS));
  // R8: no relaunch inside a window
  a_r8_no_relaunch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_o);
endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     launch_i,
  input  logic [SLOTS-1:0]         valid_i,
  input  logic [CNT_W-1:0]         remain_i,
  output logic                     we_o,
  output logic [$clog2(SLOTS)-1:0] slot_o
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOTS-1:0] pending_q;
  logic [CNT_W-1:0] pend_cnt;

  assign pend_cnt = CNT_W'($countones(pending_q));

  // lowest pending slot
  always_comb begin
    slot_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pending_q[i]) slot_o = SLOT_W'(i);
    end
  end

  // write once the remaining ticks equal the pending count
  assign we_o = (remain_i != '0) && (pending_q != '0) && (remain_i <= pend_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pending_q <= '0;
    else if (launch_i) pending_q <= valid_i;
    else if (we_o)     pending_q <= pending_q & ~(SLOTS'(1) << slot_o);
  end

  // R6: ascending slot order within a burst
  a_r6_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o)) |-> slot_o > $past(slot_o));
  // R7: all slots drained by the final tick
  a_r7_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_i == CNT_W'(1)) |=> pending_q == '0);
endmodule

// File: rtl/pgw_commit_top.sv
module pgw_commit_top #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SLOTS       = 4,
  parameter int CYCLE_TICKS = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  import pgw_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int CNT_W  = $clog2(CYCLE_TICKS + 1);

  logic              launch;
  logic [SLOTS-1:0]  valid;
  logic [PAGE_W-1:0] page;
  logic [SLOT_W-1:0] wr_slot;
  logic [CNT_W-1:0]  remain;
  phase_e            phase;

  assign launch = stop_i & ~busy_o & (|valid);

  pgw_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) u_buf (
    .clk_i, .rst_ni,
    .lock_i      (busy_o),
    .start_i, .addr_load_i, .addr_i, .byte_vld_i, .byte_i,
    .take_i      (launch),
    .rd_slot_i   (wr_slot),
    .rd_data_o   (arr_data_o),
    .page_o      (page),
    .valid_o     (valid)
  );

  pgw_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS), .CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .launch_i (launch),
    .remain_o (remain),
    .busy_o   (busy_o)
  );

  pgw_commit_seq #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .launch_i (launch),
    .valid_i  (valid),
    .remain_i (remain),
    .we_o     (arr_we_o),
    .slot_o   (wr_slot)
  );

  assign arr_addr_o = {page, wr_slot};

  always_comb begin
    if (!busy_o)       phase = PH_IDLE;
    else if (arr_we_o) phase = PH_WRITE;
    else               phase = PH_HOLD;
  end

  // R10: strobe only inside the window
  a_r10_we_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !arr_we_o);
  // R7: once writing starts it runs to the end of the window
  a_r7_write_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_WRITE |=> phase != PH_HOLD);
  // R7: the window closes right after a write
  a_r7_fall_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(arr_we_o));
  // R5: empty stop starts nothing
  a_r5_empty_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && valid == '0) |=> !busy_o);
  // R4: a valid stop opens the window
  a_r4_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy_o);
endmodule

// File: tb/sim_pgw_commit_top.sv
module sim_pgw_commit_top;
  localparam int T = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, addr_load = 1'b0, byte_vld = 1'b0, stop = 1'b0;
  logic [7:0] addr = '0, data = '0;
  logic       busy, we;
  logic [7:0] waddr, wdata;

  always #2 clk = ~clk;

  pgw_commit_top #(.CYCLE_TICKS(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_load_i(addr_load),
    .addr_i(addr), .byte_vld_i(byte_vld), .byte_i(data), .stop_i(stop),
    .busy_o(busy), .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdata));

  // behavioural reference
  int         m_cnt, m_ptr;
  bit [5:0]   m_page;
  bit [7:0]   m_buf [4];
  bit         m_val [4];
  int         q_rem[$];
  bit [7:0]   q_addr[$], q_data[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ptr = 0; m_page = '0;
      for (int i = 0; i < 4; i++) begin m_buf[i] = '0; m_val[i] = 0; end
      q_rem.delete(); q_addr.delete(); q_data.delete();
    end else if (m_cnt != 0) begin
      if (q_rem.size() > 0 && q_rem[0] == m_cnt) begin
        void'(q_rem.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
      end
      m_cnt--;
    end else begin
      int n, k;
      n = 0;
      for (int i = 0; i < 4; i++) n += m_val[i];
      if (stop && n > 0) begin
        k = 0;
        for (int s = 0; s < 4; s++) if (m_val[s]) begin
          q_rem.push_back(n - k);
          q_addr.push_back({m_page, 2'(s)});
          q_data.push_back(m_buf[s]);
          k++;
          m_val[s] = 0;
        end
        m_cnt = T;
      end
      if (start) for (int i = 0; i < 4; i++) m_val[i] = 0;
      if (addr_load) begin
        m_page = addr[7:2]; m_ptr = int'(addr[1:0]);
      end else if (byte_vld) begin
        m_buf[m_ptr] = data; m_val[m_ptr] = 1; m_ptr = (m_ptr + 1) % 4;
      end
    end
  end

  int    n_cmp = 0, n_bad = 0;
  int    w_busy, w_wr, w_fall_bad;
  bit    prev_busy, prev_we;
  string cur_req = "R1";

  task automatic compare();
    bit       e_busy, e_we;
    bit [7:0] e_a, e_d;
    e_busy = m_cnt != 0;
    e_we   = q_rem.size() > 0 && q_rem[0] == m_cnt && m_cnt != 0;
    e_a    = e_we ? q_addr[0] : 8'h00;
    e_d    = e_we ? q_data[0] : 8'h00;
    n_cmp++;
    if (busy !== e_busy || we !== e_we || (e_we && (waddr !== e_a || wdata !== e_d))) begin
      n_bad++;
      $display("FAIL %s: busy %0b/%0b we %0b/%0b addr %h/%h data %h/%h",
               cur_req, busy, e_busy, we, e_we, waddr, e_a, wdata, e_d);
    end
    if (busy) w_busy++;
    if (we) w_wr++;
    if (prev_busy && !busy && !prev_we) w_fall_bad++;
    prev_busy = busy; prev_we = we;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit st, bit al, logic [7:0] a, bit bv, logic [7:0] b, bit sp);
    start = st; addr_load = al; addr = a; byte_vld = bv; data = b; stop = sp;
    @(negedge clk);
    compare();
    start = 0; addr_load = 0; byte_vld = 0; stop = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 8'h00, 0);
  endtask
  task automatic do_start();           cyc(1, 0, 8'h00, 0, 8'h00, 0); endtask
  task automatic do_addr(logic [7:0] a); cyc(0, 1, a, 0, 8'h00, 0); endtask
  task automatic do_byte(logic [7:0] b); cyc(0, 0, 8'h00, 1, b, 0); endtask
  task automatic do_stop();            cyc(0, 0, 8'h00, 0, 8'h00, 1); endtask
  task automatic drain();
    for (int i = 0; i < 4 * T && m_cnt != 0; i++) idle(1);
    idle(2);
  endtask
  task automatic win_clear();
    w_busy = 0; w_wr = 0; w_fall_bad = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 we in reset", int'(we), 0);
    rst_n = 1'b1;
    win_clear();
    idle(3);
    chk("R1 busy after reset", w_busy, 0);
    chk("R1 no write after reset", w_wr, 0);
    do_stop();   // R1: empty mask after reset, stop does nothing
    idle(2);
    chk("R1 empty mask", w_busy, 0);

    // R2 R4 R6 R7: two bytes from slot 1
    cur_req = "R2/R4/R6/R7"; win_clear();
    do_start(); do_addr(8'h41); do_byte(8'hA1); do_byte(8'hB2); do_stop();
    drain();
    chk("R4 busy length", w_busy, T);
    chk("R6 write count", w_wr, 2);
    chk("R7 fall after write", w_fall_bad, 0);

    // R3: six bytes from slot 2 wrap and overwrite
    cur_req = "R3/R2"; win_clear();
    do_start(); do_addr(8'h8E);
    for (int i = 0; i < 6; i++) do_byte(8'h10 + 8'(i));
    do_stop();
    drain();
    chk("R3 write count", w_wr, 4);
    chk("R4 busy length wrap", w_busy, T);

    // R5: stop without data, also after dummy address
    cur_req = "R5"; win_clear();
    do_start(); do_stop(); idle(3);
    do_start(); do_addr(8'h20); do_stop(); idle(3);
    chk("R5 no cycle", w_busy, 0);
    chk("R5 no write", w_wr, 0);

    // R8: full transfer during busy is ignored
    cur_req = "R8/R10"; win_clear();
    do_start(); do_addr(8'h00); do_byte(8'h55); do_stop();
    idle(1);
    do_start(); do_addr(8'hF0); do_byte(8'hEE); do_byte(8'hEF); do_byte(8'hE0); do_stop();
    do_stop();
    drain();
    do_stop(); idle(3);
    chk("R8 single write", w_wr, 1);
    chk("R8 busy not extended", w_busy, T);

    // R9: start drops an abandoned transfer
    cur_req = "R9"; win_clear();
    do_start(); do_addr(8'h30); do_byte(8'h01); do_byte(8'h02);
    do_start(); do_stop(); idle(3);
    chk("R9 abandoned not committed", w_busy, 0);
    do_start(); do_addr(8'h33); do_byte(8'h77); do_stop();
    drain();
    chk("R9 only new slot", w_wr, 1);

    // R6 R7: full page, single slot at slot 3, back to back cycles
    cur_req = "R6/R7"; win_clear();
    do_start(); do_addr(8'hFC);
    for (int i = 0; i < 4; i++) do_byte(8'hC0 + 8'(i));
    do_stop(); drain();
    do_start(); do_addr(8'h07); do_byte(8'h9D); do_stop(); drain();
    chk("R6 writes total", w_wr, 5);
    chk("R7 fall after write total", w_fall_bad, 0);
    chk("R4 busy total", w_busy, 2 * T);

    summary();
    $finish;
  end
endmodule